// File: doc/BRIEF.md
# Dual-Group Simultaneous Conversion Sequencer

This block models the digital conversion control of an eight-channel simultaneous-sampling converter. Two start inputs each freeze one half of the channels: a rising edge on `start_a` captures the lower group of samples from `sample_in`, and a rising edge on `start_b` captures the upper group. The conversion begins only once both groups are held, a busy flag covers a fixed number of clock cycles, and when busy drops the held samples move into the result registers that a separate readout block reads.

An oversampling mode bit forbids split starts: both start inputs must then rise together. A rising edge on `conv_reset` aborts a conversion in progress and forgets a half-finished start. If the readout block signals that a read is in progress at that moment, the results are cleared to zero as well. All three control inputs are resynchronised to `clk`.

Top module: `dual_group_sequencer`

## Requirements
- R1: A start edge on `start_a` captures channels 0 to 3 (`sample_in` bits [63:0], channel n at bits [16n+15:16n]); a start edge on `start_b` captures channels 4 to 7 (bits [127:64]).
- R2: `busy` rises only after edges have been seen on both start inputs; one group held alone leaves `busy` low.
- R3: Once raised, `busy` stays high for exactly `CONV_CYCLES` clock cycles unless aborted.
- R4: Start edges arriving while `busy` is high neither re-capture samples nor start another conversion.
- R5: When `busy` falls at the end of a conversion, `result` takes the held samples; at no other time does a conversion change `result`.
- R6: With `oversample` high, a lone edge on one start input is ignored; only edges on both inputs in the same cycle start a conversion, capturing all channels.
- R7: A rising edge on `conv_reset` drops `busy` and discards the conversion in progress, so no result is latched for it.
- R8: A `conv_reset` edge with `read_active` high clears `result` to zero; with `read_active` low `result` keeps its value.
- R9: A `conv_reset` edge forgets a group already held while waiting for its partner, so the partner's later edge alone does not start a conversion.
- R10: A repeated edge on a group already waiting for its partner is ignored; the first captured samples are kept.
- R11: While `rst_n` is low, `busy` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_a | input | 1 | Start input for the lower channel group (asynchronous) |
| start_b | input | 1 | Start input for the upper channel group (asynchronous) |
| conv_reset | input | 1 | Conversion reset, acts on its rising edge (asynchronous) |
| oversample | input | 1 | Oversampling mode; high forbids split starts |
| read_active | input | 1 | High while the readout block is reading `result` |
| sample_in | input | CHANNELS*SAMPLE_W | Sample values for all channels, channel 0 in the low bits |
| busy | output | 1 | High during a conversion |
| result | output | CHANNELS*SAMPLE_W | Latched conversion results |

## Verification
The abort and the end-of-conversion latch compete for the result registers, and the conversion reset can land while the readout block is mid-read. The bench starts conversions and pulses `conv_reset` partway through, once with `read_active` low and once high. It judges that no latch follows the abort, that `result` keeps the previous conversion's value in the first case and reads zero in the second, and that later conversions still latch normally.

// File: rtl/dual_group_sequencer.sv
module dual_group_sequencer #(
  parameter int CHANNELS    = 8,
  parameter int SAMPLE_W    = 16,
  parameter int CONV_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_a,
  input  logic                         start_b,
  input  logic                         conv_reset,
  input  logic                         oversample,
  input  logic                         read_active,
  input  logic [CHANNELS*SAMPLE_W-1:0] sample_in,
  output logic                         busy,
  output logic [CHANNELS*SAMPLE_W-1:0] result
);
  localparam int HALF  = (CHANNELS / 2) * SAMPLE_W;
  localparam int BUS   = CHANNELS * SAMPLE_W;
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_a, sync_b, sync_r;
  logic                   last_a, last_b, last_r;
  logic                   pend_a, pend_b;
  logic [CNT_W-1:0]       remain;
  logic [BUS-1:0]         held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0; sync_b <= '0; sync_r <= '0;
      last_a <= 1'b0; last_b <= 1'b0; last_r <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], start_a};
      sync_b <= {sync_b[SYNC_STAGES-2:0], start_b};
      sync_r <= {sync_r[SYNC_STAGES-2:0], conv_reset};
      last_a <= sync_a[SYNC_STAGES-1];
      last_b <= sync_b[SYNC_STAGES-1];
      last_r <= sync_r[SYNC_STAGES-1];
    end

  wire rise_a   = sync_a[SYNC_STAGES-1] & ~last_a;
  wire rise_b   = sync_b[SYNC_STAGES-1] & ~last_b;
  wire rst_edge = sync_r[SYNC_STAGES-1] & ~last_r;
  wire idle     = ~busy & ~rst_edge;

  wire take_a = idle & (oversample ? (rise_a & rise_b) : (rise_a & ~pend_a));
  wire take_b = idle & (oversample ? (rise_a & rise_b) : (rise_b & ~pend_b));
  wire have_a = oversample ? rise_a : (rise_a | pend_a);
  wire have_b = oversample ? rise_b : (rise_b | pend_b);
  wire fire   = idle & have_a & have_b & (rise_a | rise_b);
  wire done   = busy & (remain == '0) & ~rst_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else if (rst_edge || fire || oversample) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      if (take_a) pend_a <= 1'b1;
      if (take_b) pend_b <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= '0;
    else begin
      if (take_a) held[HALF-1:0]   <= sample_in[HALF-1:0];
      if (take_b) held[BUS-1:HALF] <= sample_in[BUS-1:HALF];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (rst_edge) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      busy   <= 1'b1;
      remain <= CNT_W'(CONV_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       result <= '0;
    else if (rst_edge && read_active) result <= '0;
    else if (done)                    result <= held;
endmodule

module dgs_checker #(
  parameter int BUS         = 128,
  parameter int CONV_CYCLES = 400
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic [BUS-1:0] result,
  input logic           rst_edge,
  input logic           read_active,
  input logic           rise_a,
  input logic           rise_b
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;

  AST_BUSY_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rise_a | rise_b)); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(rst_edge)) |-> busy_len == CONV_CYCLES); // R3

  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(busy) && !$past(rst_edge)) |-> $stable(result)); // R5

  AST_ABORT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_edge |=> !busy); // R7

  AST_READ_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_edge && read_active) |=> result == '0); // R8

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |-> (!busy && result == '0)); // R11
endmodule

bind dual_group_sequencer dgs_checker #(
  .BUS(CHANNELS * SAMPLE_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .result(result),
  .rst_edge(rst_edge), .read_active(read_active),
  .rise_a(rise_a), .rise_b(rise_b)
);

// File: tb/tb_dual_group_sequencer.sv
module tb_dual_group_sequencer;
  localparam int CH = 8, SW = 16, CONV = 12, BUS = CH * SW, HALF = BUS / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_a = 0, start_b = 0, conv_reset = 0, oversample = 0, read_active = 0;
  logic [BUS-1:0] sample_in = '0;
  logic busy;
  logic [BUS-1:0] result;

  int vectors = 0, misses = 0, busy_len = 0;
  logic prev_busy = 1'b0;
  logic [BUS-1:0] exp_q[$];

  always #10 clk = ~clk;

  dual_group_sequencer #(.CHANNELS(CH), .SAMPLE_W(SW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .start_a(start_a), .start_b(start_b),
    .conv_reset(conv_reset), .oversample(oversample), .read_active(read_active),
    .sample_in(sample_in), .busy(busy), .result(result));

  task automatic check(input bit ok, input string req, input logic [BUS-1:0] act, input logic [BUS-1:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BUS-1:0] pat(input int seed);
    logic [BUS-1:0] v;
    for (int c = 0; c < CH; c++) v[c*SW +: SW] = 16'(seed * 4099 + c * 257 + 1);
    return v;
  endfunction

  function automatic logic [BUS-1:0] merge(input logic [BUS-1:0] lo, input logic [BUS-1:0] hi);
    return {hi[BUS-1:HALF], lo[HALF-1:0]};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk); start_a = a; start_b = b;
    cycles(3); start_a = 0; start_b = 0;
    cycles(3);
  endtask

  task automatic pulse_rst();
    @(negedge clk); conv_reset = 1;
    cycles(3); conv_reset = 0;
    cycles(3);
  endtask

  // monitor: compares every completed conversion against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_len++;
      if (prev_busy && !busy && exp_q.size() > 0) begin
        logic [BUS-1:0] e;
        e = exp_q.pop_front();
        check(result == e, "R5 latched result", result, e);
        check(busy_len == CONV, "R3 busy length", BUS'(busy_len), BUS'(CONV));
      end
      if (!busy) busy_len = 0;
      prev_busy = busy;
    end
  end

  initial begin
    cycles(200000);
    check(1'b0, "watchdog expired", '0, '1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    cycles(3);
    check(busy == 0, "R11 busy in reset", BUS'(busy), '0);
    check(result == '0, "R11 result in reset", result, '0);
    @(negedge clk); rst_n = 1;
    cycles(2);

    // split start; edges during busy must be ignored
    sample_in = pat(1);
    pulse(1, 0);
    cycles(4);
    check(busy == 0, "R2 single group held", BUS'(busy), '0);
    sample_in = pat(2);
    exp_q.push_back(merge(pat(1), pat(2)));
    pulse(0, 1);
    check(busy == 1, "R2 busy after both", BUS'(busy), BUS'(1));
    sample_in = pat(3);
    pulse(1, 1);
    cycles(20);
    check(busy == 0, "R4 no restart", BUS'(busy), '0);
    check(result == merge(pat(1), pat(2)), "R1 R4 group capture", result, merge(pat(1), pat(2)));

    // joint start
    sample_in = pat(4);
    exp_q.push_back(pat(4));
    pulse(1, 1);
    cycles(20);

    // oversampling: lone edges ignored
    oversample = 1;
    sample_in = pat(5);
    pulse(1, 0);
    cycles(4);
    check(busy == 0, "R6 lone A", BUS'(busy), '0);
    pulse(0, 1);
    cycles(4);
    check(busy == 0, "R6 lone B", BUS'(busy), '0);
    sample_in = pat(6);
    exp_q.push_back(pat(6));
    pulse(1, 1);
    cycles(20);
    check(result == pat(6), "R6 joint start", result, pat(6));
    oversample = 0;
    cycles(3);

    // abort without read
    sample_in = pat(7);
    @(negedge clk); start_a = 1; start_b = 1;
    cycles(5);
    check(busy == 1, "R2 conversion running", BUS'(busy), BUS'(1));
    pulse_rst();
    start_a = 0; start_b = 0;
    check(busy == 0, "R7 abort", BUS'(busy), '0);
    cycles(20);
    check(result == pat(6), "R7 R8 result kept", result, pat(6));

    // abort during a read
    sample_in = pat(8);
    @(negedge clk); start_a = 1; start_b = 1;
    cycles(5);
    read_active = 1;
    pulse_rst();
    read_active = 0; start_a = 0; start_b = 0;
    check(busy == 0, "R7 abort during read", BUS'(busy), '0);
    cycles(20);
    check(result == '0, "R8 cleared by read reset", result, '0);

    // reset forgets a pending group
    sample_in = pat(9);
    pulse(1, 0);
    pulse_rst();
    sample_in = pat(10);
    pulse(0, 1);
    cycles(4);
    check(busy == 0, "R9 pending cleared", BUS'(busy), '0);
    sample_in = pat(11);
    exp_q.push_back(merge(pat(11), pat(10)));
    pulse(1, 0);
    cycles(20);

    // repeated edge on a pending group
    sample_in = pat(12);
    pulse(1, 0);
    sample_in = pat(13);
    pulse(1, 0);
    cycles(4);
    check(busy == 0, "R10 repeat A no start", BUS'(busy), '0);
    sample_in = pat(14);
    exp_q.push_back(merge(pat(12), pat(14)));
    pulse(0, 1);
    cycles(20);
    check(result == merge(pat(12), pat(14)), "R10 first capture kept", result, merge(pat(12), pat(14)));

    check(exp_q.size() == 0, "R5 all conversions completed", BUS'(exp_q.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule